// File: doc/BRIEF.md
# Configurable D/T Register with Scan Chain

This block is a bank of `WIDTH` rising-edge flip-flops whose storage type is fixed at elaboration: in data mode each bit takes the data input on an enabled edge, and in toggle mode each data bit acts as a toggle enable for its own flip-flop. The bank can be cleared, set or loaded without waiting for the clock, and it can be cleared, set or loaded on an enabled clock edge. Each path has a fixed priority order. The asynchronous and synchronous set patterns and the value reached during reset are parameters.

A test mode turns the bank into a serial shift chain. Each edge moves every bit one place towards the top and brings the serial input in at the bottom. The serial output is always the top bit. The load inputs only mean something in toggle mode. With `LOAD_EN` cleared they are ignored, and enabling them on a data-mode bank stops elaboration. Reset is an active-low asynchronous input that is released through an internal two-stage synchronizer.

Top module: `dt_scan_reg`

## Requirements
- R1: In data mode (`FF_KIND = FF_DATA`), with every control low, `en` high and `test_en` low, a rising edge stores `data` in `q`.
- R2: In toggle mode (`FF_KIND = FF_TOGGLE`), under the same conditions, a rising edge inverts exactly those bits of `q` whose `data` bit is 1.
- R3: `aclr` drives `q` to all zeros at once, without a clock edge. It overrides `aset` and `aload`, so when `aclr` and `aset` are both high the result is zero.
- R4: `aset` drives `q` to `ASET_VAL` (all ones by default) at once, without a clock edge, and it overrides `aload`.
- R5: With `LOAD_EN` set, `aload` copies `data` into `q` at once, without a clock edge.
- R6: While any asynchronous control is high, clock edges leave `q` at the asynchronous value, whatever the states of `test_en`, `en` and the synchronous controls.
- R7: On an edge with `en` high and `test_en` low, `sclr` gives zero, otherwise `sset` gives `SSET_VAL`, otherwise `sload` (only with `LOAD_EN` set) gives `data`. With `en` low the synchronous controls have no effect.
- R8: With `en` low, `test_en` low and no asynchronous control high, a rising edge leaves `q` unchanged.
- R9: With `test_en` high and no asynchronous control high, each rising edge makes `q` equal to `{q[WIDTH-2:0], scan_in}`, whatever the states of `en` and the synchronous controls. `scan_out` always equals `q[WIDTH-1]`.
- R10: While `rst_n` is low, `q` equals `PON_VAL`. After `rst_n` rises, the first two rising edges leave `q` at `PON_VAL`, and the third edge is the first to act normally.
- R11: With `LOAD_EN` cleared, `aload` and `sload` have no effect. Elaboration is rejected if `WIDTH` is 0 or if `LOAD_EN` is set in data mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset to `PON_VAL`, released synchronously |
| data | input | WIDTH | Next state (data mode), toggle enables (toggle mode), or load value |
| en | input | 1 | Clock enable for normal and synchronous-control activity |
| aclr | input | 1 | Asynchronous clear |
| aset | input | 1 | Asynchronous set to `ASET_VAL` |
| aload | input | 1 | Asynchronous load of `data` (toggle mode with `LOAD_EN` only) |
| sclr | input | 1 | Synchronous clear |
| sset | input | 1 | Synchronous set to `SSET_VAL` |
| sload | input | 1 | Synchronous load of `data` (toggle mode with `LOAD_EN` only) |
| test_en | input | 1 | Scan shift enable |
| scan_in | input | 1 | Serial scan input into bit 0 |
| q | output | WIDTH | Register contents |
| scan_out | output | 1 | Serial scan output, the top bit of `q` |

## Verification
Asynchronous clear, set and load results are due within the same time step as the stimulus. The bench therefore samples them 1 ns after driving the control, before any clock edge arrives. Every synchronous, toggle, hold and scan result is due on the first rising edge after the inputs change at the falling edge. The vector loop samples 1 ns after that rising edge and compares against a model updated once per edge. Reset release is counted out in full: the checks expect `PON_VAL` after the first and second edges and the first real update after the third.

// File: rtl/dtsr_pkg.sv
package dtsr_pkg;

  typedef enum logic {
    FF_DATA   = 1'b0,
    FF_TOGGLE = 1'b1
  } ff_kind_e;

endpackage

// File: rtl/dtsr_rst_sync.sv
module dtsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  if (STAGES < 2) begin : g_bad_stages
    $error("dtsr_rst_sync: STAGES must be at least 2");
  end

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_out_n = sync_q[STAGES-1];

endmodule

// File: rtl/dtsr_next.sv
module dtsr_next
  import dtsr_pkg::*;
#(
  parameter int       WIDTH    = 8,
  parameter ff_kind_e FF_KIND  = FF_DATA,
  parameter bit       LOAD_EN  = 1'b0,
  parameter logic [WIDTH-1:0] SSET_VAL = '1
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] data,
  input  logic             en,
  input  logic             sclr,
  input  logic             sset,
  input  logic             sload,
  input  logic             test_en,
  input  logic             scan_in,
  output logic [WIDTH-1:0] d_next
);

  logic [WIDTH-1:0] func_v;
  logic [WIDTH-1:0] shift_v;
  logic             sload_ok;

  // Normal clocked function chosen by the storage type
  if (FF_KIND == FF_TOGGLE) begin : g_toggle
    assign func_v = q ^ data;
  end else begin : g_data
    assign func_v = data;
  end

  // Scan path: bit i moves to bit i+1, serial input enters bit 0
  if (WIDTH == 1) begin : g_shift_one
    assign shift_v = scan_in;
  end else begin : g_shift_many
    assign shift_v = {q[WIDTH-2:0], scan_in};
  end

  // R11: synchronous load is honoured only when load ports are enabled
  if (LOAD_EN) begin : g_sload_on
    assign sload_ok = sload;
  end else begin : g_sload_off
    assign sload_ok = 1'b0;
  end

  // R7 R8 R9: test shift, then enable gating, then clear > set > load
  always_comb begin
    if (test_en) begin
      d_next = shift_v;
    end else if (!en) begin
      d_next = q;
    end else if (sclr) begin
      d_next = '0;
    end else if (sset) begin
      d_next = SSET_VAL;
    end else if (sload_ok) begin
      d_next = data;
    end else begin
      d_next = func_v;
    end
  end

endmodule

// File: rtl/dtsr_bank.sv
module dtsr_bank #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] ASET_VAL = '1,
  parameter logic [WIDTH-1:0] PON_VAL  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             aclr,
  input  logic             aset,
  input  logic             aload,
  input  logic [WIDTH-1:0] load_val,
  input  logic [WIDTH-1:0] d_next,
  output logic [WIDTH-1:0] q
);

  // R3 R4 R5 R6 R10: asynchronous controls beat everything clocked
  always_ff @(posedge clk or negedge rst_n or posedge aclr or posedge aset or posedge aload) begin
    if (!rst_n) begin
      q <= PON_VAL;
    end else if (aclr) begin
      q <= '0;
    end else if (aset) begin
      q <= ASET_VAL;
    end else if (aload) begin
      q <= load_val;
    end else begin
      q <= d_next;
    end
  end

endmodule

// File: rtl/dt_scan_reg.sv
module dt_scan_reg
  import dtsr_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter ff_kind_e         FF_KIND  = FF_DATA,
  parameter bit               LOAD_EN  = 1'b0,
  parameter logic [WIDTH-1:0] ASET_VAL = '1,
  parameter logic [WIDTH-1:0] SSET_VAL = '1,
  parameter logic [WIDTH-1:0] PON_VAL  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] data,
  input  logic             en,
  input  logic             aclr,
  input  logic             aset,
  input  logic             aload,
  input  logic             sclr,
  input  logic             sset,
  input  logic             sload,
  input  logic             test_en,
  input  logic             scan_in,
  output logic [WIDTH-1:0] q,
  output logic             scan_out
);

  localparam int RST_STAGES = 2;

  // R11: parameter legality
  if (WIDTH < 1) begin : g_bad_width
    $error("dt_scan_reg: WIDTH must be at least 1");
  end
  if (LOAD_EN && (FF_KIND == FF_DATA)) begin : g_bad_load
    $error("dt_scan_reg: load ports may only be enabled in toggle mode");
  end

  logic             rst_core_n;
  logic             aload_eff;
  logic [WIDTH-1:0] d_next;

  // R11: asynchronous load is disconnected when load ports are disabled
  if (LOAD_EN) begin : g_aload_on
    assign aload_eff = aload;
  end else begin : g_aload_off
    assign aload_eff = 1'b0;
  end

  dtsr_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_core_n)
  );

  dtsr_next #(
    .WIDTH    (WIDTH),
    .FF_KIND  (FF_KIND),
    .LOAD_EN  (LOAD_EN),
    .SSET_VAL (SSET_VAL)
  ) u_next (
    .q       (q),
    .data    (data),
    .en      (en),
    .sclr    (sclr),
    .sset    (sset),
    .sload   (sload),
    .test_en (test_en),
    .scan_in (scan_in),
    .d_next  (d_next)
  );

  dtsr_bank #(
    .WIDTH    (WIDTH),
    .ASET_VAL (ASET_VAL),
    .PON_VAL  (PON_VAL)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .aclr     (aclr),
    .aset     (aset),
    .aload    (aload_eff),
    .load_val (data),
    .d_next   (d_next),
    .q        (q)
  );

  // R9: serial output is the top bit
  assign scan_out = q[WIDTH-1];

endmodule

// File: rtl/dt_scan_reg_chk.sv
module dt_scan_reg_chk #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] ASET_VAL = '1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             aclr,
  input logic             aset,
  input logic             aload,
  input logic             sclr,
  input logic             en,
  input logic             test_en,
  input logic             scan_in,
  input logic [WIDTH-1:0] q
);

  logic async_any;
  assign async_any = aclr | aset | aload;

  // Conflicting asynchronous requests resolve to clear, flagged here
  always @(posedge clk) begin
    if (rst_n && aclr && aset) begin
      $warning("dt_scan_reg: aclr and aset both high, clear applied");
    end
  end

  AST_ACLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    aclr |-> (q == '0))
    else $error("aclr did not hold q at zero"); // R3

  AST_ASET_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (aset && !aclr) |=> (aclr || !aset || (q == ASET_VAL)))
    else $error("aset did not hold q at its set value"); // R4

  AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_any && test_en) |=> (async_any || (q == WIDTH'({$past(q), $past(scan_in)}))))
    else $error("scan shift produced a wrong value"); // R9

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_any && !test_en && !en) |=> (async_any || $stable(q)))
    else $error("q changed with enable low"); // R8

  AST_SCLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_any && !test_en && en && sclr) |=> (async_any || (q == '0)))
    else $error("synchronous clear not applied"); // R7

endmodule

bind dt_scan_reg dt_scan_reg_chk #(
  .WIDTH    (WIDTH),
  .ASET_VAL (ASET_VAL)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .aclr    (aclr),
  .aset    (aset),
  .aload   (aload_eff),
  .sclr    (sclr),
  .en      (en),
  .test_en (test_en),
  .scan_in (scan_in),
  .q       (q)
);

// File: tb/dt_scan_reg_bench.sv
module dt_scan_reg_bench;
  import dtsr_pkg::*;

  localparam int         W      = 8;
  localparam logic [7:0] T_ASET = 8'hA5;
  localparam logic [7:0] T_SSET = 8'h3C;
  localparam logic [7:0] T_PON  = 8'h5A;
  localparam logic [7:0] D_ASET = 8'hFF;
  localparam logic [7:0] D_SSET = 8'hFF;
  localparam logic [7:0] D_PON  = 8'h00;

  // Vector layout: [16]aclr [15]aset [14]aload [13]sclr [12]sset [11]sload
  //                [10]en [9]test_en [8]scan_in [7:0]data
  localparam int NV = 20;
  localparam logic [16:0] VEC [NV] = '{
    {9'b000000100, 8'h0F},  // plain enabled edge
    {9'b000000100, 8'hF0},
    {9'b000000000, 8'h33},  // enable low: hold
    {9'b000100100, 8'h33},  // sclr
    {9'b000111100, 8'h77},  // sclr beats sset, sload
    {9'b000011100, 8'h77},  // sset beats sload
    {9'b000001100, 8'h77},  // sload
    {9'b000100000, 8'h00},  // sclr with enable low: hold
    {9'b000100011, 8'h00},  // scan shift in 1, sclr ignored
    {9'b000010110, 8'h00},  // scan shift in 0, sset ignored
    {9'b001000000, 8'h81},  // aload
    {9'b010100100, 8'h00},  // aset with sclr and en
    {9'b011000000, 8'h12},  // aset beats aload
    {9'b110000010, 8'h00},  // aclr and aset with test
    {9'b000000100, 8'hFF},
    {9'b101000100, 8'h3C},  // aclr beats aload
    {9'b000000011, 8'h00},
    {9'b000000010, 8'h00},
    {9'b000000100, 8'h55},
    {9'b000000111, 8'h0C}
  };

  logic         clk;
  logic         rst_n;
  logic [W-1:0] data;
  logic         en, aclr, aset, aload, sclr, sset, sload, test_en, scan_in;
  logic [W-1:0] q_t, q_d;
  logic         so_t, so_d;

  int  n_checks;
  int  n_errors;
  bit  done;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  dt_scan_reg #(
    .WIDTH    (W),
    .FF_KIND  (FF_TOGGLE),
    .LOAD_EN  (1'b1),
    .ASET_VAL (T_ASET),
    .SSET_VAL (T_SSET),
    .PON_VAL  (T_PON)
  ) u_dt_scan_reg (
    .clk (clk), .rst_n (rst_n), .data (data), .en (en),
    .aclr (aclr), .aset (aset), .aload (aload),
    .sclr (sclr), .sset (sset), .sload (sload),
    .test_en (test_en), .scan_in (scan_in),
    .q (q_t), .scan_out (so_t)
  );

  dt_scan_reg #(
    .WIDTH    (W),
    .FF_KIND  (FF_DATA),
    .LOAD_EN  (1'b0)
  ) u_dt_scan_reg_d (
    .clk (clk), .rst_n (rst_n), .data (data), .en (en),
    .aclr (aclr), .aset (aset), .aload (aload),
    .sclr (sclr), .sset (sset), .sload (sload),
    .test_en (test_en), .scan_in (scan_in),
    .q (q_d), .scan_out (so_d)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference behaviour of one bank for one step, written from the requirements
  function automatic logic [7:0] model(input logic [7:0] cur, input logic [16:0] v,
                                       input bit tmode, input bit lden,
                                       input logic [7:0] aval, input logic [7:0] sval);
    if (v[16])                return 8'h00;
    else if (v[15])           return aval;
    else if (v[14] && lden)   return v[7:0];
    else if (v[9])            return {cur[6:0], v[8]};
    else if (!v[10])          return cur;
    else if (v[13])           return 8'h00;
    else if (v[12])           return sval;
    else if (v[11] && lden)   return v[7:0];
    else if (tmode)           return cur ^ v[7:0];
    else                      return v[7:0];
  endfunction

  function automatic string tag_of(input logic [16:0] v, input bit tmode);
    if (v[16])                    return "R3,R6";
    else if (v[15])               return "R4,R6";
    else if (v[14] && tmode)      return "R5";
    else if (v[14])               return "R11";
    else if (v[9])                return "R9";
    else if (!v[10])              return "R8";
    else if (v[13] | v[12] | v[11]) return "R7";
    else if (tmode)               return "R2";
    else                          return "R1";
  endfunction

  task automatic drive(input logic [16:0] v);
    {aclr, aset, aload, sclr, sset, sload, en, test_en, scan_in} = v[16:8];
    data = v[7:0];
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] mt, md;
    n_checks = 0;
    n_errors = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    drive(17'h0);

    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset toggle bank", q_t, T_PON);
    check("R10 reset data bank", q_d, D_PON);

    // R10: release, two edges still at power-on value, third acts
    @(negedge clk);
    rst_n = 1'b1;
    drive({9'b000000100, 8'hFF});
    @(posedge clk); #1;
    check("R10 first edge after release", q_t, T_PON);
    @(posedge clk); #1;
    check("R10 second edge after release", q_d, D_PON);
    @(posedge clk); #1;
    check("R10 third edge toggle", q_t, 8'hA5);
    check("R10 third edge data", q_d, 8'hFF);
    mt = 8'hA5;
    md = 8'hFF;

    // Vector walk: inputs change at falling edge, results sampled after rising edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(posedge clk); #1;
      mt = model(mt, VEC[i], 1'b1, 1'b1, T_ASET, T_SSET);
      md = model(md, VEC[i], 1'b0, 1'b0, D_ASET, D_SSET);
      check($sformatf("%s vector %0d toggle bank", tag_of(VEC[i], 1'b1), i), q_t, mt);
      check($sformatf("%s vector %0d data bank", tag_of(VEC[i], 1'b0), i), q_d, md);
      check($sformatf("R9 scan_out vector %0d", i), {7'd0, so_t}, {7'd0, mt[7]});
    end

    // Directed: asynchronous effects appear before any clock edge
    @(negedge clk);
    drive(17'h0);
    #1;
    aset = 1'b1;
    #1;
    check("R4 immediate aset toggle bank", q_t, T_ASET);
    check("R4 immediate aset data bank", q_d, D_ASET);
    @(negedge clk);
    aset = 1'b0;
    #1;
    data  = 8'hC3;
    aload = 1'b1;
    #1;
    check("R5 immediate aload toggle bank", q_t, 8'hC3);
    check("R11 aload ignored data bank", q_d, D_ASET);
    @(negedge clk);
    aload = 1'b0;
    #1;
    aclr = 1'b1;
    aset = 1'b1;
    #1;
    check("R3 immediate aclr over aset toggle bank", q_t, 8'h00);
    check("R3 immediate aclr over aset data bank", q_d, 8'h00);
    @(negedge clk);
    aclr = 1'b0;
    aset = 1'b0;

    // R11: synchronous load ignored in data bank with enable low
    @(negedge clk);
    drive({9'b000001000, 8'h99});
    @(posedge clk); #1;
    check("R11 sload ignored data bank", q_d, 8'h00);
    check("R8 sload without enable toggle bank", q_t, 8'h00);

    // R9: fill the chain with ones, scan_out reaches 1 after eight shifts
    for (int k = 0; k < W; k++) begin
      @(negedge clk);
      drive({9'b000000011, 8'h00});
      @(posedge clk); #1;
    end
    check("R9 chain full toggle bank", q_t, 8'hFF);
    check("R9 scan_out top bit", {7'd0, so_d}, 8'h01);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule